// File: doc/BRIEF.md
# External Interrupt Line Conditioner

This block takes four asynchronous interrupt pins from outside the chip and turns them into clean, clock-synchronous request signals for an interrupt controller. Each pin passes through a two-flop synchroniser. A per-line sense mode then interprets it as an active-high level, an active-low level, a rising edge or a falling edge. Edge events are held in a small per-line state machine until software clears them.

A single 32-bit control word, written over a plain write-strobe register bus and always visible on a read-data port, holds all line configuration. Each line n has a 2-bit sense field at bits [23−2n:22−2n], an enable at bit 11−n and a write-only clear strobe at bit 27−n. Bit 12 is a master enable and bit 0 selects the routing of line 0. Line 0 normally drives the critical request output. Lines 1 to 3 drive positions 1 to 3 of the main request vector.

Each line's edge state machine has two states. EV_IDLE means no event is held. EV_HELD means an edge event is latched. It has three transitions:
- capture: EV_IDLE or EV_HELD goes to EV_HELD on a qualifying edge.
- release: EV_HELD goes to EV_IDLE on a clear strobe when no new edge arrives in the same cycle.
- flush: any state goes to EV_IDLE when a write changes that line's sense field.

Top module: `ext_irq_conditioner`

## Requirements
- R1: After reset the control word reads 0, and `crit_req` and `main_req` are 0.
- R2: A write stores bits 23:16, 12, 11:8 and 0 of `bus_wdata`. The read port then shows exactly those bits. Every other bit, including the clear strobes 27:24, reads 0.
- R3: Sense code 0 (level-high) makes the request follow the pin. Code 3 (level-low) makes it follow the inverted pin. A pin change reaches the output after two clock edges.
- R4: Sense code 1 latches a rising edge and code 2 latches a falling edge. The request stays high after the pin returns to its idle level.
- R5: Writing 1 to bit 27−n drops the latched event of line n only, one edge after the write.
- R6: If a clear strobe and a new qualifying edge of the same line fall on the same clock edge, the event stays latched.
- R7: A write that changes a line's sense field discards that line's latched event.
- R8: The line enable at bit 11−n gates only the output. An edge caught while the line is disabled appears once the line is enabled.
- R9: While the master enable (bit 12) is 0, no request output is asserted.
- R10: With bit 0 set, line 0 drives `crit_req`. With bit 0 clear, line 0 drives `main_req[0]` and `crit_req` stays 0.
- R11: Lines 1, 2 and 3 drive `main_req[1]`, `main_req[2]` and `main_req[3]` respectively, and nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Control word write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Current control word |
| irq_pin | input | 4 | Asynchronous external interrupt pins |
| crit_req | output | 1 | Critical request from line 0 |
| main_req | output | 4 | Main-level requests; bit 0 is line 0 when rerouted |

## Verification
A wrong edge state appears at the ports as a request that never rises after a qualifying edge, or one that stays high after a clear or mode change. Either is visible on the first clock edge after the event plus the synchroniser delay. A corrupted register field shows up on `bus_rdata` one edge after the write. It also shows up as a request on the wrong output position, or under the wrong pin polarity, after two edges. The sweep steps every line through all four sense codes, so a misplaced field or swapped mapping lands on a line whose expected output differs.

// File: rtl/eil_pkg.sv
package eil_pkg;
    typedef enum logic [1:0] {
        SNS_LVL_HI = 2'd0,
        SNS_RISE   = 2'd1,
        SNS_FALL   = 2'd2,
        SNS_LVL_LO = 2'd3
    } sense_e;

    typedef enum logic {
        EV_IDLE = 1'b0,
        EV_HELD = 1'b1
    } ev_state_e;

    localparam int CTRL_W     = 32;
    localparam int MASTER_BIT = 12;
    localparam int ROUTE_BIT  = 0;

    function automatic int sense_lsb(input int n);
        return 22 - 2 * n;
    endfunction

    function automatic int enable_bit(input int n);
        return 11 - n;
    endfunction

    function automatic int clear_bit(input int n);
        return 27 - n;
    endfunction

    function automatic logic [CTRL_W-1:0] keep_mask(input int lines);
        logic [CTRL_W-1:0] m;
        m = '0;
        m[MASTER_BIT] = 1'b1;
        m[ROUTE_BIT]  = 1'b1;
        for (int i = 0; i < lines; i++) begin
            m[sense_lsb(i)]     = 1'b1;
            m[sense_lsb(i) + 1] = 1'b1;
            m[enable_bit(i)]    = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/eil_sync.sv
module eil_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/eil_ctrl_reg.sv
module eil_ctrl_reg
    import eil_pkg::*;
#(
    parameter int NUM_LINES = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr,
    input  logic [CTRL_W-1:0]          wdata,
    output logic [CTRL_W-1:0]          rdata,
    output logic [NUM_LINES-1:0][1:0]  sense,
    output logic [NUM_LINES-1:0]       line_en,
    output logic                       master_en,
    output logic                       route_norm,
    output logic [NUM_LINES-1:0]       clr_pulse,
    output logic [NUM_LINES-1:0]       mode_chg
);
    localparam logic [CTRL_W-1:0] KEEP = keep_mask(NUM_LINES);

    logic [CTRL_W-1:0] ctrl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  ctrl_q <= '0;
        else if (wr) ctrl_q <= wdata & KEEP;
    end

    assign rdata      = ctrl_q;
    assign master_en  = ctrl_q[MASTER_BIT];
    assign route_norm = ctrl_q[ROUTE_BIT];

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_field
        localparam int SL = sense_lsb(n);
        localparam int EB = enable_bit(n);
        localparam int CB = clear_bit(n);
        assign sense[n]     = ctrl_q[SL +: 2];
        assign line_en[n]   = ctrl_q[EB];
        assign clr_pulse[n] = wr & wdata[CB];
        assign mode_chg[n]  = wr & (wdata[SL +: 2] != ctrl_q[SL +: 2]);
    end
endmodule

// File: rtl/eil_line.sv
module eil_line
    import eil_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl,
    input  logic [1:0] mode,
    input  logic       clr,
    input  logic       mode_chg,
    input  logic       act,
    output logic       req
);
    ev_state_e state_q, state_d;
    logic      prev_q;
    logic      edge_hit;
    logic      raw;
    sense_e    sns;

    assign sns = sense_e'(mode);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    assign edge_hit = ((sns == SNS_RISE) &&  lvl && !prev_q) ||
                      ((sns == SNS_FALL) && !lvl &&  prev_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EV_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EV_IDLE: begin
                if (mode_chg)      state_d = EV_IDLE;
                else if (edge_hit) state_d = EV_HELD;
            end
            EV_HELD: begin
                if (mode_chg)      state_d = EV_IDLE;
                else if (edge_hit) state_d = EV_HELD;
                else if (clr)      state_d = EV_IDLE;
            end
        endcase
    end

    always_comb begin
        unique case (sns)
            SNS_LVL_HI: raw = lvl;
            SNS_LVL_LO: raw = !lvl;
            default:    raw = (state_q == EV_HELD);
        endcase
        req = act & raw;
    end
endmodule

// File: rtl/ext_irq_conditioner.sv
module ext_irq_conditioner
    import eil_pkg::*;
#(
    parameter int NUM_LINES   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] irq_pin,
    output logic                 crit_req,
    output logic [NUM_LINES-1:0] main_req
);
    logic [NUM_LINES-1:0]      pin_s;
    logic [NUM_LINES-1:0][1:0] sense;
    logic [NUM_LINES-1:0]      line_en, clr_pulse, mode_chg, line_req;
    logic                      master_en, route_norm;

    eil_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(irq_pin), .q(pin_s)
    );

    eil_ctrl_reg #(.NUM_LINES(NUM_LINES)) u_reg (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .wdata(bus_wdata),
        .rdata(bus_rdata), .sense(sense), .line_en(line_en),
        .master_en(master_en), .route_norm(route_norm),
        .clr_pulse(clr_pulse), .mode_chg(mode_chg)
    );

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        eil_line u_line (
            .clk(clk), .rst_n(rst_n), .lvl(pin_s[n]), .mode(sense[n]),
            .clr(clr_pulse[n]), .mode_chg(mode_chg[n]),
            .act(master_en & line_en[n]), .req(line_req[n])
        );
    end

    assign crit_req = route_norm & line_req[0];
    always_comb begin
        main_req    = line_req;
        main_req[0] = !route_norm & line_req[0];
    end
endmodule

// File: rtl/ext_irq_conditioner_chk.sv
module ext_irq_conditioner_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic [3:0]  pin_s,
    input logic        crit_req,
    input logic [3:0]  main_req
);
    logic [3:0] any_req;
    assign any_req = {main_req[3:1], crit_req | main_req[0]};

    // R9
    master_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rdata[12] |-> (!crit_req && main_req == 4'd0));

    // R10
    route_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rdata[0] |-> !crit_req);

    // R2
    readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> bus_rdata == ($past(bus_wdata) & 32'h00FF_1F01));

    for (genvar n = 0; n < 4; n++) begin : g_ln
        // R3
        level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rdata[12] && bus_rdata[11-n] && bus_rdata[23-2*n -: 2] == 2'd0)
                |-> any_req[n] == pin_s[n]);

        // R4
        edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rdata[12] && bus_rdata[11-n] && !bus_wr && any_req[n] &&
             (bus_rdata[23-2*n -: 2] == 2'd1 || bus_rdata[23-2*n -: 2] == 2'd2))
                |=> any_req[n]);
    end
endmodule

bind ext_irq_conditioner ext_irq_conditioner_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_s(pin_s), .crit_req(crit_req),
    .main_req(main_req)
);

// File: tb/ext_irq_conditioner_test.sv
module ext_irq_conditioner_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_pin = '0;
    logic        crit_req;
    logic [3:0]  main_req;

    int checks = 0;
    int fails  = 0;
    logic [31:0] cfg;

    always #2 clk = ~clk;

    ext_irq_conditioner uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_pin(irq_pin), .crit_req(crit_req),
        .main_req(main_req)
    );

    localparam logic [31:0] MASTER = 32'h0000_1000;
    localparam logic [31:0] ROUTE  = 32'h0000_0001;

    function automatic logic [31:0] f_sense(int n, int m);
        return 32'(m) << (22 - 2 * n);
    endfunction
    function automatic logic [31:0] f_en(int n);  return 32'd1 << (11 - n); endfunction
    function automatic logic [31:0] f_clr(int n); return 32'd1 << (27 - n); endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic cyc(int k);
        repeat (k) @(negedge clk);
    endtask

    function automatic logic [4:0] outs();
        return {main_req, crit_req};
    endfunction

    // expected {main_req, crit_req} with line n requesting, route normal
    function automatic logic [4:0] one(int n);
        return (n == 0) ? 5'b00001 : (5'b00001 << (n + 1));
    endfunction

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        cyc(3);
        // R1
        chk("R1 rdata", bus_rdata, 32'd0);
        chk("R1 outs", 32'(outs()), 32'd0);
        rst_n = 1'b1;
        cyc(2);

        // R2 readback with strobes and unused bits set
        wr(32'hFFFF_FFFF);
        chk("R2 all-ones", bus_rdata, 32'h00FF_1F01);
        wr(32'hA5A5_5A5A);
        chk("R2 pattern", bus_rdata, 32'hA5A5_5A5A & 32'h00FF_1F01);
        wr(32'h0);

        // Sweep: every line through every sense code (R3 R4 R5 R11)
        for (int n = 0; n < 4; n++) begin
            irq_pin = '0; cyc(4);
            for (int m = 0; m < 4; m++) begin
                logic idle_lvl;
                logic edge_md;
                idle_lvl = (m == 2 || m == 3);
                edge_md  = (m == 1 || m == 2);
                cfg = MASTER | ROUTE | f_en(n) | f_sense(n, m);
                wr(cfg);
                irq_pin[n] = idle_lvl; cyc(4);
                chk(edge_md ? "R4 idle" : "R3 idle", 32'(outs()), 32'd0);
                irq_pin[n] = !idle_lvl; cyc(4);
                chk(edge_md ? "R4 active" : "R3 active R11", 32'(outs()), 32'(one(n)));
                irq_pin[n] = idle_lvl; cyc(4);
                chk(edge_md ? "R4 held" : "R3 released", 32'(outs()),
                    edge_md ? 32'(one(n)) : 32'd0);
                if (edge_md) begin
                    wr(cfg | f_clr((n + 1) % 4));
                    chk("R5 other line clear", 32'(outs()), 32'(one(n)));
                    wr(cfg | f_clr(n));
                    chk("R5 clear", 32'(outs()), 32'd0);
                end
            end
        end

        // R3 two-edge latency, line 1 level-high
        irq_pin = '0;
        cfg = MASTER | ROUTE | f_en(1);
        wr(cfg); cyc(3);
        irq_pin[1] = 1'b1;
        @(negedge clk);
        chk("R3 after one edge", 32'(main_req[1]), 32'd0);
        @(negedge clk);
        chk("R3 after two edges", 32'(main_req[1]), 32'd1);

        // R6 clear coinciding with a new edge, line 2 rising
        irq_pin = '0;
        cfg = MASTER | ROUTE | f_en(2) | f_sense(2, 1);
        wr(cfg); cyc(3);
        irq_pin[2] = 1'b1; cyc(4);
        irq_pin[2] = 1'b0; cyc(4);
        chk("R6 pre", 32'(main_req[2]), 32'd1);
        irq_pin[2] = 1'b1;       // driven at a falling edge
        @(posedge clk); @(posedge clk); // edge seen during next cycle
        @(negedge clk); bus_wr = 1'b1; bus_wdata = cfg | f_clr(2);
        @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
        chk("R6 edge wins", 32'(main_req[2]), 32'd1);
        wr(cfg | f_clr(2));
        chk("R6 later clear", 32'(main_req[2]), 32'd0);

        // R7 mode change discards, line 3 falling -> rising
        irq_pin = 4'b1000;
        cfg = MASTER | ROUTE | f_en(3) | f_sense(3, 2);
        wr(cfg); cyc(4);
        irq_pin[3] = 1'b0; cyc(4);
        chk("R7 pre", 32'(main_req[3]), 32'd1);
        wr(MASTER | ROUTE | f_en(3) | f_sense(3, 1));
        chk("R7 mode change", 32'(main_req[3]), 32'd0);

        // R8 edge caught while disabled, line 0 rising
        irq_pin = '0;
        cfg = MASTER | ROUTE | f_sense(0, 1);
        wr(cfg); cyc(3);
        irq_pin[0] = 1'b1; cyc(4);
        chk("R8 disabled", 32'(outs()), 32'd0);
        wr(cfg | f_en(0));
        chk("R8 enabled", 32'(crit_req), 32'd1);

        // R9 master off hides it, back on shows it
        wr(ROUTE | f_en(0) | f_sense(0, 1));
        chk("R9 master off", 32'(outs()), 32'd0);
        wr(MASTER | ROUTE | f_en(0) | f_sense(0, 1));
        chk("R9 master on", 32'(crit_req), 32'd1);

        // R10 reroute line 0 to main_req[0]
        wr(MASTER | f_en(0) | f_sense(0, 1));
        chk("R10 rerouted", 32'(outs()), 32'b00010);
        wr(MASTER | ROUTE | f_en(0) | f_sense(0, 1));
        chk("R10 normal", 32'(outs()), 32'b00001);

        // R11 all lines level-high, map each pin
        cfg = MASTER | ROUTE | 32'h0000_0F00;
        wr(cfg);
        for (int p = 0; p < 16; p++) begin
            irq_pin = 4'(p); cyc(3);
            chk("R11 map", 32'(outs()), 32'({irq_pin[3:1], 1'b0, irq_pin[0]}));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule